// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sits next to the core of a small controller and decides which clocks run. Software asks for one of two low-power states by pulsing a request for idle or for power-down. In idle the core clock stops while peripherals, timers and interrupt logic keep their clock. In power-down every clock stops, including the oscillator. The block owns the two request bits and clears them when it leaves a state, so software can read back which state it was in.

The external reset pin is measured in machine cycles, counted with an oscillator-clock phase counter. The internal reset only asserts after the pin has stayed high for two complete machine cycles with the oscillator running. Idle ends on any enabled interrupt or on a qualified reset. Power-down ends only on a qualified reset.

A reset that arrives during idle restarts the core clock at once. From then until the internal reset takes over, writes to internal RAM are blocked. Power-down wins over idle when both are requested together.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: One cycle after the synchronous controller reset is released, the core, peripheral and oscillator enables are 1. The internal reset, the RAM write block, and both mode bits are 0.
- R2: The internal reset asserts only after the reset pin has been high for two full machine cycles with the oscillator running. It never asserts before 2*CLKS_PER_MC oscillator cycles, and always by 3*CLKS_PER_MC+3. A shorter pulse causes no reset. The internal reset releases within two cycles of the pin falling and clears both mode bits.
- R3: An idle request in the run state sets the idle bit. From the next cycle the core clock enable is 0, while the peripheral and oscillator enables stay 1.
- R4: In idle, an interrupt request whose enable bit is 1 clears the idle bit on the next cycle. The core clock enable returns at the following machine-cycle boundary, within CLKS_PER_MC+1 cycles. An interrupt whose enable bit is 0 has no effect.
- R5: A power-down request in the run state sets the power-down bit. From the next cycle the core, peripheral and oscillator enables are all 0.
- R6: When idle and power-down are requested in the same cycle, power-down is entered and the idle bit stays 0.
- R7: In power-down, interrupts have no effect. Only a qualified reset leaves that state.
- R8: In power-down, a high reset pin raises the oscillator enable. The qualification count does not advance until the oscillator-running input is 1.
- R9: A reset pin rising in idle brings the core clock enable back on the next cycle and raises the RAM write block. The block stays up until the internal reset has been released.
- R10: Mode requests made outside the run state are ignored.
- R11: The RAM write block is 1 whenever the internal reset is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset of the controller itself |
| idle_req | input | 1 | Software pulse requesting idle |
| pdown_req | input | 1 | Software pulse requesting power-down |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| rst_pin | input | 1 | External reset pin, active high |
| osc_running | input | 1 | Oscillator is running and stable |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| idle_bit | output | 1 | Idle request bit |
| pdown_bit | output | 1 | Power-down request bit |

## Verification
The hardest case to reach is reset qualification from power-down. The oscillator enable rises with the pin, but counting must wait for a separate oscillator-running indication. The stimulus enters power-down, drops osc_running, raises the pin and waits several machine cycles with no reset. It then raises osc_running and checks that the reset appears inside the qualification window. The machine-cycle phase is not visible at the ports, so qualification is checked against a lower and an upper bound rather than a single cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_WAKE,
        ST_RSTWIN,
        ST_PDOWN,
        ST_INRST
    } lp_state_e;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic osc_en;
        logic ram_blk;
    } gate_t;

    // Clock gating and RAM protection as a function of mode and pin level
    function automatic gate_t gates_for(lp_state_e s, logic pin);
        gate_t g;
        case (s)
            ST_IDLE, ST_WAKE: g = '{cpu_en: 1'b0, per_en: 1'b1, osc_en: 1'b1, ram_blk: 1'b0};
            ST_RSTWIN:        g = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_blk: 1'b1};
            ST_PDOWN:         g = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: pin,  ram_blk: 1'b0};
            ST_INRST:         g = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_blk: 1'b1};
            default:          g = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_blk: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mc_timer.sv
module mc_timer #(
    parameter int CLKS_PER_MC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic mc_end
);
    localparam int PH_W = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_MC - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (tick_en) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    assign mc_end = tick_en && (phase == PH_LAST);

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(phase)) else $error("phase moved without oscillator"); // R8
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
    parameter int CLKS_PER_MC = 12,
    parameter int QUAL_MC     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    input  logic osc_live,
    input  logic mc_end,
    output logic qual
);
    localparam int CNT_MAX = QUAL_MC + 1;
    localparam int Q_W     = $clog2(CNT_MAX + 1);
    localparam int HT_MAX  = (QUAL_MC + 1) * CLKS_PER_MC;
    localparam int HT_W    = $clog2(HT_MAX + 1);

    logic [Q_W-1:0] cnt;

    // The first boundary seen with the pin high opens a full machine cycle;
    // QUAL_MC further boundaries complete the qualification.
    always_ff @(posedge clk) begin
        if (rst || !rst_pin) begin
            cnt <= '0;
        end else if (mc_end && cnt != Q_W'(CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == Q_W'(CNT_MAX));

    // Checker: oscillator cycles seen with the pin high
    logic [HT_W-1:0] hi_ticks;
    always_ff @(posedge clk) begin
        if (rst || !rst_pin) begin
            hi_ticks <= '0;
        end else if (osc_live && hi_ticks != HT_W'(HT_MAX)) begin
            hi_ticks <= hi_ticks + 1'b1;
        end
    end

    AST_QUAL_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(qual) |-> (hi_ticks >= HT_W'(QUAL_MC * CLKS_PER_MC))) else $error("reset qualified early"); // R2
    AST_QUAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (rst_pin && !osc_live) |=> (cnt == $past(cnt))) else $error("count moved with oscillator stopped"); // R8
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      idle_req,
    input  logic      pdown_req,
    input  logic      wake_any,
    input  logic      rst_pin,
    input  logic      rst_qual,
    input  logic      mc_end,
    output lp_state_e st,
    output logic      idle_bit,
    output logic      pdown_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RUN;
            idle_bit  <= 1'b0;
            pdown_bit <= 1'b0;
        end else if (rst_qual) begin
            st        <= ST_INRST;
            idle_bit  <= 1'b0;
            pdown_bit <= 1'b0;
        end else begin
            case (st)
                ST_RUN: begin
                    if (pdown_req) begin
                        st        <= ST_PDOWN;
                        pdown_bit <= 1'b1;
                    end else if (idle_req) begin
                        st       <= ST_IDLE;
                        idle_bit <= 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (rst_pin) begin
                        st <= ST_RSTWIN;
                    end else if (wake_any) begin
                        st       <= ST_WAKE;
                        idle_bit <= 1'b0;
                    end
                end
                ST_RSTWIN: if (!rst_pin) st <= ST_IDLE;
                ST_WAKE:   if (mc_end)   st <= ST_RUN;
                ST_PDOWN:  st <= ST_PDOWN;
                default:   st <= ST_RUN;
            endcase
        end
    end

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({idle_bit, pdown_bit})) else $error("two mode bits set"); // R6
    AST_PD_EXIT_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(pdown_bit) |-> $past(rst_qual)) else $error("power-down left without reset"); // R7
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_bit) |-> ($past(rst_qual) || $past(wake_any))) else $error("idle left without cause"); // R4
    AST_WAKE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && $past(st) == ST_WAKE) |-> $past(mc_end)) else $error("wake off boundary"); // R4
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int CLKS_PER_MC = 12,
    parameter int QUAL_MC     = 2,
    parameter int N_IRQ       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_req,
    input  logic             pdown_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             rst_pin,
    input  logic             osc_running,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             int_rst,
    output logic             ram_wr_block,
    output logic             idle_bit,
    output logic             pdown_bit
);
    lp_state_e st;
    gate_t     gates;
    logic      tick_en;
    logic      mc_end;
    logic      rst_qual;
    logic      wake_any;

    assign wake_any = |(irq_req & irq_en);
    assign gates    = gates_for(st, rst_pin);
    assign tick_en  = gates.osc_en & osc_running;

    mc_timer #(.CLKS_PER_MC(CLKS_PER_MC)) u_mc (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .mc_end  (mc_end)
    );

    rst_qualifier #(.CLKS_PER_MC(CLKS_PER_MC), .QUAL_MC(QUAL_MC)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .rst_pin  (rst_pin),
        .osc_live (tick_en),
        .mc_end   (mc_end),
        .qual     (rst_qual)
    );

    lp_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .idle_req  (idle_req),
        .pdown_req (pdown_req),
        .wake_any  (wake_any),
        .rst_pin   (rst_pin),
        .rst_qual  (rst_qual),
        .mc_end    (mc_end),
        .st        (st),
        .idle_bit  (idle_bit),
        .pdown_bit (pdown_bit)
    );

    assign cpu_clk_en    = gates.cpu_en;
    assign periph_clk_en = gates.per_en;
    assign osc_en        = gates.osc_en;
    assign int_rst       = rst_qual;
    assign ram_wr_block  = gates.ram_blk | rst_qual;

    AST_BLOCK_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_wr_block) |-> $past(rst_pin)) else $error("RAM block without reset pin"); // R9
    AST_RST_BLOCKS_RAM: assert property (@(posedge clk) disable iff (rst)
        int_rst |-> ram_wr_block) else $error("RAM open during reset"); // R11
    AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
        (pdown_bit && !int_rst) |-> (!cpu_clk_en && !periph_clk_en)) else $error("clock on in power-down"); // R5
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
    localparam int C  = 12;
    localparam int NI = 5;

    logic clk = 1'b0;
    logic rst, idle_req, pdown_req, rst_pin, osc_running;
    logic [NI-1:0] irq_req, irq_en;
    logic cpu_clk_en, periph_clk_en, osc_en, int_rst, ram_wr_block, idle_bit, pdown_bit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.CLKS_PER_MC(C), .QUAL_MC(2), .N_IRQ(NI)) dut_i (
        .clk(clk), .rst(rst), .idle_req(idle_req), .pdown_req(pdown_req),
        .irq_req(irq_req), .irq_en(irq_en), .rst_pin(rst_pin), .osc_running(osc_running),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .int_rst(int_rst), .ram_wr_block(ram_wr_block), .idle_bit(idle_bit), .pdown_bit(pdown_bit)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(logic i, logic p);
        idle_req = i; pdown_req = p;
        cyc(1);
        idle_req = 0; pdown_req = 0;
    endtask

    // Qualified reset from any state, oscillator running
    task automatic pin_reset(string req);
        rst_pin = 1;
        cyc(3*C + 3);
        chk(req, "int_rst after hold", int_rst, 1);
        chk("R11", "ram block in reset", ram_wr_block, 1);
        rst_pin = 0;
        cyc(2);
        chk(req, "int_rst released", int_rst, 0);
        chk(req, "cpu on after reset", cpu_clk_en, 1);
    endtask

    task automatic t_reset_state;
        chk("R1", "cpu_clk_en", cpu_clk_en, 1);
        chk("R1", "periph_clk_en", periph_clk_en, 1);
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "int_rst", int_rst, 0);
        chk("R1", "ram_wr_block", ram_wr_block, 0);
        chk("R1", "idle_bit", idle_bit, 0);
        chk("R1", "pdown_bit", pdown_bit, 0);
    endtask

    task automatic t_idle_irq;
        int waited;
        pulse_req(1, 0);
        chk("R3", "cpu off in idle", cpu_clk_en, 0);
        chk("R3", "periph on in idle", periph_clk_en, 1);
        chk("R3", "osc on in idle", osc_en, 1);
        chk("R3", "idle_bit", idle_bit, 1);
        pulse_req(0, 1);
        chk("R10", "pdown ignored in idle", pdown_bit, 0);
        chk("R10", "osc still on", osc_en, 1);
        irq_en = '0; irq_req = 5'b00100;
        cyc(3);
        chk("R4", "masked irq keeps idle", idle_bit, 1);
        chk("R4", "masked irq keeps cpu off", cpu_clk_en, 0);
        irq_en = 5'b00100;
        cyc(1);
        irq_req = '0;
        chk("R4", "idle_bit cleared", idle_bit, 0);
        chk("R4", "cpu waits for boundary", cpu_clk_en, 0);
        waited = 1;
        while (!cpu_clk_en && waited < C + 4) begin
            cyc(1);
            waited++;
        end
        chk("R4", "cpu back within one machine cycle", (waited <= C + 1), 1);
        irq_en = '1;
    endtask

    task automatic t_pdown;
        pulse_req(0, 1);
        chk("R5", "pdown_bit", pdown_bit, 1);
        chk("R5", "cpu off", cpu_clk_en, 0);
        chk("R5", "periph off", periph_clk_en, 0);
        chk("R5", "osc off", osc_en, 0);
        irq_req = '1;
        cyc(2);
        irq_req = '0;
        cyc(1);
        chk("R7", "irq ignored in power-down", pdown_bit, 1);
        chk("R7", "cpu still off", cpu_clk_en, 0);
        osc_running = 0;
        rst_pin = 1;
        cyc(1);
        chk("R8", "osc enabled by pin", osc_en, 1);
        cyc(4*C);
        chk("R8", "no reset while oscillator stopped", int_rst, 0);
        osc_running = 1;
        cyc(3*C + 3);
        chk("R8", "reset after oscillator start", int_rst, 1);
        chk("R2", "pdown_bit cleared by reset", pdown_bit, 0);
        chk("R11", "ram block in reset", ram_wr_block, 1);
        rst_pin = 0;
        cyc(2);
        chk("R2", "int_rst released", int_rst, 0);
        chk("R7", "cpu on after reset", cpu_clk_en, 1);
        chk("R7", "osc on after reset", osc_en, 1);
    endtask

    task automatic t_both;
        pulse_req(1, 1);
        chk("R6", "pdown wins", pdown_bit, 1);
        chk("R6", "idle stays clear", idle_bit, 0);
        chk("R6", "osc off", osc_en, 0);
        pin_reset("R6");
    endtask

    task automatic t_short;
        rst_pin = 1;
        cyc(2*C - 1);
        chk("R2", "no reset before two cycles", int_rst, 0);
        rst_pin = 0;
        cyc(3);
        chk("R2", "short pulse ignored", int_rst, 0);
        chk("R2", "cpu still on", cpu_clk_en, 1);
    endtask

    task automatic t_idle_rst;
        pulse_req(1, 0);
        chk("R3", "in idle", cpu_clk_en, 0);
        rst_pin = 1;
        cyc(1);
        chk("R9", "cpu resumes at reset", cpu_clk_en, 1);
        chk("R9", "RAM writes blocked", ram_wr_block, 1);
        chk("R9", "not yet reset", int_rst, 0);
        cyc(3*C + 2);
        chk("R9", "reset taken", int_rst, 1);
        chk("R9", "idle_bit cleared", idle_bit, 0);
        chk("R11", "block during reset", ram_wr_block, 1);
        rst_pin = 0;
        cyc(2);
        chk("R9", "block released", ram_wr_block, 0);
        chk("R9", "cpu running", cpu_clk_en, 1);
    endtask

    initial begin
        rst = 1; idle_req = 0; pdown_req = 0; rst_pin = 0; osc_running = 1;
        irq_req = '0; irq_en = '1;
        cyc(3);
        rst = 0;
        cyc(1);
        t_reset_state();
        t_idle_irq();
        t_pdown();
        t_both();
        t_short();
        t_idle_rst();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule